// File: doc/BRIEF.md
# Address/GPIO Port Mode Multiplexer

This block drives the two 8-bit output ports of an 8051-class microcontroller. Each port either shows a value that software has written into a small register, so it works as a general-purpose output, or it carries one byte of the external program/data address bus. The low port carries the low address byte and the high port carries the high address byte. When the core fetches from external program memory (`ea_int` low), both ports are forced into address mode whatever the mode bits hold.

Three byte registers live in external data space. The mode register is at 0x200, the low-port data register is at 0x201 and the high-port data register is at 0x202. Software reaches them with plain bus reads and writes. Whether an access reaches them depends on a compatibility select. With the select at 0, a port-bit gate must be 1. With the select at 1, the gate is ignored, and instead the memory-select input must be 0 and `ea_int` must be 1.

In low-port address mode, the port holds the low address byte that was captured on the last clock edge with `ale` high. In high-port address mode, the high address byte passes straight through to the port.

Top module: `addr_port_mux`

## Requirements
- R1: After a synchronous active-high reset, both ports output 0x00 and the mode register reads 0x00.
- R2: In general-purpose mode, `lo_port` equals the register at 0x201 and `hi_port` equals the register at 0x202. An allowed write changes the port on the clock edge that samples `bus_wr`.
- R3: When the high mode bit (bit 4 of 0x200) is 1 or `ea_int` is 0, `hi_port` equals `hi_addr` in the same cycle.
- R4: When the low mode bit (bit 3 of 0x200) is 1 or `ea_int` is 0, `lo_port` shows the `lo_addr` value captured at the most recent clock edge with `ale` high, and holds it while `ale` is low. The capture happens on every `ale`-high edge, whatever the mode.
- R5: With `ea_int` at 0, both ports are in address mode for all four mode-bit settings. The stored register values reappear on the ports once `ea_int` returns to 1 with the mode bits at 0.
- R6: Writing 0x200 stores only data bits 3 and 4. Reading 0x200 returns those two bits in place, with every other bit 0.
- R7: With `compat_sel` at 0, register access is allowed exactly when `port_gate` is 1. `mem_sel_n` has no effect in this case.
- R8: With `compat_sel` at 1, access is allowed exactly when `mem_sel_n` is 0 and `ea_int` is 1. `port_gate` has no effect in this case.
- R9: A write that is not allowed leaves all three registers unchanged. A read that is not allowed returns 0x00, and so does a read of any address outside 0x200 to 0x202.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ea_int | input | 1 | 1 = internal program memory, 0 = external program memory |
| ale | input | 1 | Address latch enable for the low address byte |
| lo_addr | input | 8 | Internal low address byte |
| hi_addr | input | 8 | Internal high address byte |
| compat_sel | input | 1 | Access rule select: 0 = gated by `port_gate`, 1 = gated by `mem_sel_n` and `ea_int` |
| port_gate | input | 1 | Port-bit gate used when `compat_sel` is 0 |
| mem_sel_n | input | 1 | Memory select, must be 0 for access when `compat_sel` is 1 |
| bus_addr | input | 16 | External data space address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| lo_port | output | 8 | Low output port |
| hi_port | output | 8 | High output port |

## Verification
The hardest situation to reach combines four things. A register write must arrive while its port is in address mode, the access gate must be closed or open at that same moment, and the write's effect must be seen later, once `ea_int` or the mode bit returns the port to general-purpose mode. Random stimulus reaches these combinations by biasing addresses tightly around 0x200 to 0x202 and holding `ea_int` at 1 most of the time. It also randomizes all the gate inputs on every cycle, so the mode register flips often. Directed sequences first cover reset, forcing by `ea_int`, and `ale` capture and hold.

// File: rtl/addr_port_mux.sv
module addr_port_mux #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] BASE = 16'h0200,
  parameter int LO_BIT = 3,
  parameter int HI_BIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ea_int,
  input  logic          ale,
  input  logic [DW-1:0] lo_addr,
  input  logic [DW-1:0] hi_addr,
  input  logic          compat_sel,
  input  logic          port_gate,
  input  logic          mem_sel_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] lo_port,
  output logic [DW-1:0] hi_port
);
  localparam logic [AW-1:0] A_CFG = BASE;
  localparam logic [AW-1:0] A_LO  = BASE + 1'b1;
  localparam logic [AW-1:0] A_HI  = BASE + 2'd2;

  logic          mode_lo, mode_hi;
  logic [DW-1:0] lo_reg, hi_reg, lo_latch;
  logic          acc_ok, lo_am, hi_am;

  assign acc_ok = compat_sel ? (!mem_sel_n && ea_int) : port_gate;
  assign lo_am  = !ea_int || mode_lo;
  assign hi_am  = !ea_int || mode_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_lo <= 1'b0;
      mode_hi <= 1'b0;
      lo_reg  <= '0;
      hi_reg  <= '0;
    end else if (bus_wr && acc_ok) begin
      if (bus_addr == A_CFG) begin
        mode_lo <= bus_wdata[LO_BIT];
        mode_hi <= bus_wdata[HI_BIT];
      end
      if (bus_addr == A_LO) lo_reg <= bus_wdata;
      if (bus_addr == A_HI) hi_reg <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      lo_latch <= '0;
    else if (ale) lo_latch <= lo_addr;
  end

  assign lo_port = lo_am ? lo_latch : lo_reg;
  assign hi_port = hi_am ? hi_addr : hi_reg;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && acc_ok) begin
      if (bus_addr == A_CFG) begin
        bus_rdata[LO_BIT] = mode_lo;
        bus_rdata[HI_BIT] = mode_hi;
      end
      if (bus_addr == A_LO) bus_rdata = lo_reg;
      if (bus_addr == A_HI) bus_rdata = hi_reg;
    end
  end

  assert_gp_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && acc_ok && bus_addr == A_HI && ea_int) ##1 (ea_int && !mode_hi)
      |-> hi_port == $past(bus_wdata));

  assert_ea_force_R5: assert property (@(posedge clk) disable iff (rst)
    !ea_int |-> hi_port == hi_addr);

  assert_ale_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (ale && lo_am) |=> (!lo_am || lo_port == $past(lo_addr)));

  assert_ale_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ale && lo_am) |=> (!lo_am || $stable(lo_port)));

  assert_blocked_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !acc_ok) |=> ($stable(lo_reg) && $stable(hi_reg) && $stable(mode_lo) && $stable(mode_hi)));

  assert_blocked_read_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !acc_ok) |-> bus_rdata == '0);

  assert_cfg_read_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && acc_ok && bus_addr == A_CFG) |-> ((bus_rdata & ~8'h18) == '0));
endmodule

// File: tb/addr_port_mux_tb.sv
module addr_port_mux_tb;
  logic clk = 0, rst = 1;
  logic ea_int = 1, ale = 0, compat_sel = 0, port_gate = 0, mem_sel_n = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] lo_addr = 0, hi_addr = 0, bus_wdata = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] bus_rdata, lo_port, hi_port;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic m_lo_mode = 0, m_hi_mode = 0;
  logic [7:0] m_lo = 0, m_hi = 0, m_latch = 0;

  always #2.5 clk = ~clk;

  addr_port_mux u_dut (
    .clk(clk), .rst(rst), .ea_int(ea_int), .ale(ale), .lo_addr(lo_addr), .hi_addr(hi_addr),
    .compat_sel(compat_sel), .port_gate(port_gate), .mem_sel_n(mem_sel_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .lo_port(lo_port), .hi_port(hi_port));

  function automatic logic allowed();
    return compat_sel ? (!mem_sel_n && ea_int) : port_gate;
  endfunction
  function automatic logic [7:0] exp_lo();
    return (!ea_int || m_lo_mode) ? m_latch : m_lo;
  endfunction
  function automatic logic [7:0] exp_hi();
    return (!ea_int || m_hi_mode) ? hi_addr : m_hi;
  endfunction
  function automatic logic [7:0] exp_rd();
    if (!bus_rd || !allowed()) return 8'h00;
    case (bus_addr)
      16'h0200: return {3'b000, m_hi_mode, m_lo_mode, 3'b000};
      16'h0201: return m_lo;
      16'h0202: return m_hi;
      default:  return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string rl, rh, rr;
    rl = !ea_int ? "R5" : (m_lo_mode ? "R4" : "R2");
    rh = !ea_int ? "R5" : (m_hi_mode ? "R3" : "R2");
    if (!allowed() || bus_addr > 16'h0202 || bus_addr < 16'h0200) rr = "R9";
    else if (bus_addr == 16'h0200) rr = "R6";
    else rr = compat_sel ? "R8" : "R7";
    check(rl, lo_port, exp_lo());
    check(rh, hi_port, exp_hi());
    if (bus_rd) check(rr, bus_rdata, exp_rd());
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    if (bus_wr && allowed()) begin
      if (bus_addr == 16'h0200) begin m_lo_mode = bus_wdata[3]; m_hi_mode = bus_wdata[4]; end
      if (bus_addr == 16'h0201) m_lo = bus_wdata;
      if (bus_addr == 16'h0202) m_hi = bus_wdata;
    end
    if (ale) m_latch = lo_addr;
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; ale = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    idle(); bus_addr = a; bus_wdata = d; bus_wr = 1; step(); idle();
  endtask

  task automatic rd(input logic [15:0] a);
    idle(); bus_addr = a; bus_rd = 1; step(); idle();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    port_gate = 1;
    check("R1", lo_port, 8'h00);
    check("R1", hi_port, 8'h00);
    rd(16'h0200);
    // R2: gp writes
    wr(16'h0201, 8'hA5); wr(16'h0202, 8'h3C); step();
    // R6: only bits 3,4 stored
    wr(16'h0200, 8'hFF); rd(16'h0200);
    // R3 / R4: address modes, ale capture and hold
    hi_addr = 8'h77; lo_addr = 8'h12; ale = 1; step();
    ale = 0; lo_addr = 8'h99; step(); step();
    wr(16'h0200, 8'h08); hi_addr = 8'h55; step();
    // R5: ea forcing with all bits, then return
    for (int b = 0; b < 4; b++) begin
      port_gate = 1; ea_int = 1; wr(16'h0200, 8'(b << 3));
      ea_int = 0; hi_addr = 8'(b * 17); lo_addr = 8'(b + 40); ale = 1; step(); ale = 0; step();
    end
    ea_int = 1; wr(16'h0200, 8'h00); step();
    // R7: gate closed blocks, mem_sel_n irrelevant
    compat_sel = 0; port_gate = 0; mem_sel_n = 0;
    wr(16'h0201, 8'h11); rd(16'h0201); port_gate = 1; rd(16'h0201);
    // R8: compat path
    compat_sel = 1; port_gate = 1; mem_sel_n = 1;
    wr(16'h0202, 8'h22); rd(16'h0202);
    port_gate = 0; mem_sel_n = 0; wr(16'h0202, 8'h44); rd(16'h0202);
    ea_int = 0; wr(16'h0201, 8'h66); ea_int = 1; rd(16'h0201);
    // R9: out-of-range read
    rd(16'h0203); rd(16'h01FF);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      ea_int     = ($urandom % 8) != 0;
      ale        = $urandom % 2;
      lo_addr    = $urandom; hi_addr = $urandom;
      compat_sel = $urandom % 2; port_gate = $urandom % 2; mem_sel_n = $urandom % 2;
      bus_addr   = 16'h01FF + ($urandom % 5);
      if ($urandom % 16 == 0) bus_addr = $urandom;
      bus_wdata  = $urandom;
      bus_wr     = ($urandom % 3) == 0;
      bus_rd     = ($urandom % 2) == 0;
      step();
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule